// File: doc/BRIEF.md
# Pitch-Linear Rectangle Copy and Fill Engine

The engine moves bytes between two pitch-linear regions of a byte-addressed memory. A controller sets up a source base, a destination base, a pitch for each side, a line length in bytes and a line count, then pulses `start`. In rectangle mode the engine walks the rows one at a time. Each row's source and destination addresses step by their own pitch. In single-run mode it moves one contiguous run of `line_len` bytes. A remap setting with the constant-A selector on the first destination component turns the job into a fill of 32-bit words with a constant.

All memory traffic goes through one request/grant port that has a 32-bit data path and byte enables. Each row is read whole into a local row buffer and then written out, so overlapping regions give a fixed, row-ordered result. Whole words are moved when every address involved is word-aligned. Otherwise the engine moves one byte per beat. When the job ends, the engine pulses `done`, and `err` marks any setup it refuses.

Top module: `lin2d_copy`

## Requirements
- R1: After reset `mem_req` and `done` are low and stay low until a job is started.
- R2: Setup inputs are captured only when `start` is high while the engine is idle. A `start` pulse or a setup change during a job has no effect on that job.
- R3: With `multi_line` low and `remap_en` low, `line_len` bytes are copied from `src_base` to `dst_base`.
- R4: With `multi_line` high and `remap_en` low, row n (n = 0 to `line_cnt`-1) copies `line_len` bytes from `src_base`+n*`src_pitch` to `dst_base`+n*`dst_pitch`. Each row is read entirely before any of its bytes are written, so overlapping regions behave as row-by-row buffered copies.
- R5: A copy uses word beats (`mem_be`=4'hF, address bits [1:0]=0) when both bases and `line_len` are multiples of 4, and also both pitches in rectangle mode. Otherwise it uses byte beats, with `mem_be` one-hot at lane address[1:0]. Byte write data carries the byte replicated in every lane.
- R6: With `remap_en` high, `multi_line` low, `remap_dst_sel`=3'd4 (constant A), `comp_size_m1`=2'd3 and `dst_base` word-aligned, the engine writes `line_len` words of `const_a` at `dst_base`+4k for k = 0 to `line_len`-1, with `mem_be`=4'hF.
- R7: The following setups end with `done` and `err` high and no memory beats: remap with `multi_line`; remap with any other `remap_dst_sel`; fill with `comp_size_m1`≠3; fill with a `dst_base` that is not word-aligned; a copy with `line_len` > MAX_LINE (64 by default) that has nonzero work.
- R8: A copy with `line_len`=0, or in rectangle mode with `line_cnt`=0, completes with `done`, `err` low and no beats. This check comes before the MAX_LINE check. A fill with `line_len`=0 also completes with no beats.
- R9: A beat is taken in a cycle where `mem_req` and `mem_gnt` are both high. Until then, address, direction, enables and write data hold steady. Read data is taken from `mem_rdata` in the granting cycle.
- R10: `done` is a one-cycle pulse. It comes in the cycle after the last granted beat, or in the cycle after `start` when the job has no beats. `mem_req` is low while `done` is high, and `err` is high only together with `done`.
- R11: Beats are issued in ascending address order: all reads of a row, then all writes of that row, then the next row. Fill words are issued in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a job (sampled while idle) |
| multi_line | input | 1 | Rectangle mode when high |
| remap_en | input | 1 | Remap (fill) request |
| remap_dst_sel | input | 3 | First destination component selector, 4 = constant A |
| comp_size_m1 | input | 2 | Component size minus one |
| src_base | input | AW | Source base byte address |
| dst_base | input | AW | Destination base byte address |
| src_pitch | input | AW | Source row pitch in bytes |
| dst_pitch | input | AW | Destination row pitch in bytes |
| line_len | input | LEN_W | Bytes per row (words for fill) |
| line_cnt | input | CNT_W | Rows in rectangle mode |
| const_a | input | 32 | Fill value |
| done | output | 1 | Job finished pulse |
| err | output | 1 | Job refused, valid with done |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | AW | Beat byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables |
| mem_gnt | input | 1 | Beat accepted |
| mem_rdata | input | 32 | Read data of the addressed word, valid with grant |

## Verification
A wrong row or offset register shows up at the very next granted beat as a wrong `mem_addr`, a wrong direction or a wrong enable pattern. Every granted beat is compared against the bench's expected queue, so this kind of error appears within one cycle. A corrupted row buffer entry shows up only when that byte is written back, at most one row's worth of beats later, as a mismatch in the masked write data. A wrong row count or end-of-job decision shows up as a `done` that arrives early or late relative to the last beat, or as beats left over in the queue.

// File: rtl/lin2d_pkg.sv
package lin2d_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_FILL,
        ST_DONE
    } lin2d_st_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_COPY,
        OP_FILL,
        OP_ERR
    } lin2d_op_e;

    // Selector code meaning "constant A" on the first destination component
    localparam logic [2:0] SEL_CONST_A = 3'd4;
    // Component size field value for 4-byte components
    localparam logic [1:0] COMP_FOUR_B = 2'd3;

endpackage

// File: rtl/lin2d_op_dec.sv
module lin2d_op_dec
    import lin2d_pkg::*;
#(
    parameter int LEN_W    = 16,
    parameter int CNT_W    = 16,
    parameter int MAX_LINE = 64
) (
    input  logic             multi_line,
    input  logic             remap_en,
    input  logic [2:0]       remap_dst_sel,
    input  logic [1:0]       comp_size_m1,
    input  logic [1:0]       src_lo,
    input  logic [1:0]       dst_lo,
    input  logic [1:0]       src_pitch_lo,
    input  logic [1:0]       dst_pitch_lo,
    input  logic [LEN_W-1:0] line_len,
    input  logic [CNT_W-1:0] line_cnt,
    output lin2d_op_e        op,
    output logic             word_mode,
    output logic [CNT_W-1:0] rows
);

    localparam logic [LEN_W:0] LIMIT = (LEN_W+1)'(MAX_LINE);

    logic pitch_ok;

    always_comb begin
        rows      = multi_line ? line_cnt : CNT_W'(1);
        pitch_ok  = !multi_line || (src_pitch_lo == 2'b00 && dst_pitch_lo == 2'b00);
        word_mode = (src_lo == 2'b00) && (dst_lo == 2'b00) &&
                    (line_len[1:0] == 2'b00) && pitch_ok;

        if (remap_en) begin
            if (multi_line || remap_dst_sel != SEL_CONST_A ||
                comp_size_m1 != COMP_FOUR_B || dst_lo != 2'b00) begin
                op = OP_ERR;
            end else if (line_len == '0) begin
                op = OP_NONE;
            end else begin
                op = OP_FILL;
            end
        end else if (line_len == '0 || rows == '0) begin
            op = OP_NONE;
        end else if ({1'b0, line_len} > LIMIT) begin
            op = OP_ERR;
        end else begin
            op = OP_COPY;
        end
    end

endmodule

// File: rtl/lin2d_row_buf.sv
module lin2d_row_buf #(
    parameter int DEPTH = 64,
    parameter int BIW   = 6
) (
    input  logic           clk,
    input  logic           wr_en,
    input  logic           wr_word,
    input  logic [BIW-1:0] wr_idx,
    input  logic [31:0]    wr_data,
    input  logic [BIW-1:0] rd_idx,
    output logic [31:0]    rd_data
);

    logic [7:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < 4; i++) begin
                if ((i == 0 || wr_word) && (int'(wr_idx) + i < DEPTH)) begin
                    store_q[wr_idx + BIW'(i)] <= wr_data[8*i +: 8];
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < 4; i++) begin
            if (int'(rd_idx) + i < DEPTH) begin
                rd_data[8*i +: 8] = store_q[rd_idx + BIW'(i)];
            end
        end
    end

endmodule

// File: rtl/lin2d_copy.sv
module lin2d_copy
    import lin2d_pkg::*;
#(
    parameter int AW       = 32,
    parameter int LEN_W    = 16,
    parameter int CNT_W    = 16,
    parameter int MAX_LINE = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             multi_line,
    input  logic             remap_en,
    input  logic [2:0]       remap_dst_sel,
    input  logic [1:0]       comp_size_m1,
    input  logic [AW-1:0]    src_base,
    input  logic [AW-1:0]    dst_base,
    input  logic [AW-1:0]    src_pitch,
    input  logic [AW-1:0]    dst_pitch,
    input  logic [LEN_W-1:0] line_len,
    input  logic [CNT_W-1:0] line_cnt,
    input  logic [31:0]      const_a,
    output logic             done,
    output logic             err,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [31:0]      mem_wdata,
    output logic [3:0]       mem_be,
    input  logic             mem_gnt,
    input  logic [31:0]      mem_rdata
);

    localparam int BIW = (MAX_LINE > 1) ? $clog2(MAX_LINE) : 1;

    typedef struct packed {
        lin2d_st_e        st;
        logic [AW-1:0]    src_row;
        logic [AW-1:0]    dst_row;
        logic [AW-1:0]    src_pitch;
        logic [AW-1:0]    dst_pitch;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] off;
        logic [CNT_W-1:0] rows;
        logic [CNT_W-1:0] row;
        logic             word;
        logic [31:0]      fill_val;
        logic             err;
    } eng_t;

    eng_t eng_d, eng_q;

    lin2d_op_e        dec_op;
    logic             dec_word;
    logic [CNT_W-1:0] dec_rows;

    logic           buf_we;
    logic [31:0]    buf_wdata;
    logic [31:0]    buf_rdata;

    logic [LEN_W:0]   off_step;
    logic [LEN_W:0]   off_inc;
    logic [LEN_W-1:0] step;
    logic [3:0]       lane_be;
    logic [7:0]       lane_byte;
    logic [CNT_W-1:0] row_nx;

    lin2d_op_dec #(
        .LEN_W   (LEN_W),
        .CNT_W   (CNT_W),
        .MAX_LINE(MAX_LINE)
    ) u_dec (
        .multi_line   (multi_line),
        .remap_en     (remap_en),
        .remap_dst_sel(remap_dst_sel),
        .comp_size_m1 (comp_size_m1),
        .src_lo       (src_base[1:0]),
        .dst_lo       (dst_base[1:0]),
        .src_pitch_lo (src_pitch[1:0]),
        .dst_pitch_lo (dst_pitch[1:0]),
        .line_len     (line_len),
        .line_cnt     (line_cnt),
        .op           (dec_op),
        .word_mode    (dec_word),
        .rows         (dec_rows)
    );

    lin2d_row_buf #(
        .DEPTH(MAX_LINE),
        .BIW  (BIW)
    ) u_buf (
        .clk    (clk),
        .wr_en  (buf_we),
        .wr_word(eng_q.word),
        .wr_idx (eng_q.off[BIW-1:0]),
        .wr_data(buf_wdata),
        .rd_idx (eng_q.off[BIW-1:0]),
        .rd_data(buf_rdata)
    );

    always_comb begin
        eng_d     = eng_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        mem_be    = '0;
        buf_we    = 1'b0;
        buf_wdata = '0;

        step     = eng_q.word ? LEN_W'(4) : LEN_W'(1);
        off_step = {1'b0, eng_q.off} + {1'b0, step};
        off_inc  = {1'b0, eng_q.off} + (LEN_W+1)'(1);
        row_nx   = eng_q.row + CNT_W'(1);

        unique case (eng_q.st)
            ST_READ:  mem_addr = eng_q.src_row + AW'(eng_q.off);
            ST_WRITE: mem_addr = eng_q.dst_row + AW'(eng_q.off);
            ST_FILL:  mem_addr = eng_q.dst_row + (AW'(eng_q.off) << 2);
            default:  mem_addr = '0;
        endcase

        lane_be = 4'b0001 << mem_addr[1:0];
        unique case (mem_addr[1:0])
            2'd0:    lane_byte = mem_rdata[7:0];
            2'd1:    lane_byte = mem_rdata[15:8];
            2'd2:    lane_byte = mem_rdata[23:16];
            default: lane_byte = mem_rdata[31:24];
        endcase

        unique case (eng_q.st)
            ST_IDLE: begin
                if (start) begin
                    eng_d.src_row   = src_base;
                    eng_d.dst_row   = dst_base;
                    eng_d.src_pitch = src_pitch;
                    eng_d.dst_pitch = dst_pitch;
                    eng_d.len       = line_len;
                    eng_d.rows      = dec_rows;
                    eng_d.word      = dec_word;
                    eng_d.fill_val  = const_a;
                    eng_d.off       = '0;
                    eng_d.row       = '0;
                    eng_d.err       = 1'b0;
                    unique case (dec_op)
                        OP_COPY: eng_d.st = ST_READ;
                        OP_FILL: eng_d.st = ST_FILL;
                        OP_ERR: begin
                            eng_d.st  = ST_DONE;
                            eng_d.err = 1'b1;
                        end
                        default: eng_d.st = ST_DONE;
                    endcase
                end
            end
            ST_READ: begin
                mem_req = 1'b1;
                mem_be  = eng_q.word ? 4'hF : lane_be;
                if (mem_gnt) begin
                    buf_we    = 1'b1;
                    buf_wdata = eng_q.word ? mem_rdata : {24'h0, lane_byte};
                    eng_d.off = off_step[LEN_W-1:0];
                    if (off_step >= {1'b0, eng_q.len}) begin
                        eng_d.off = '0;
                        eng_d.st  = ST_WRITE;
                    end
                end
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = eng_q.word ? 4'hF : lane_be;
                mem_wdata = eng_q.word ? buf_rdata : {4{buf_rdata[7:0]}};
                if (mem_gnt) begin
                    eng_d.off = off_step[LEN_W-1:0];
                    if (off_step >= {1'b0, eng_q.len}) begin
                        eng_d.off = '0;
                        eng_d.row = row_nx;
                        if (row_nx == eng_q.rows) begin
                            eng_d.st = ST_DONE;
                        end else begin
                            eng_d.st      = ST_READ;
                            eng_d.src_row = eng_q.src_row + eng_q.src_pitch;
                            eng_d.dst_row = eng_q.dst_row + eng_q.dst_pitch;
                        end
                    end
                end
            end
            ST_FILL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_be    = 4'hF;
                mem_wdata = eng_q.fill_val;
                if (mem_gnt) begin
                    eng_d.off = off_inc[LEN_W-1:0];
                    if (off_inc >= {1'b0, eng_q.len}) begin
                        eng_d.st = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                eng_d.st = ST_IDLE;
            end
            default: begin
                eng_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q    <= '0;
            eng_q.st <= ST_IDLE;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign done = (eng_q.st == ST_DONE);
    assign err  = done && eng_q.err;

endmodule

// File: rtl/lin2d_copy_chk.sv
module lin2d_copy_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic          err,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_gnt,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic [3:0]    mem_be
);

    // R9: an ungranted request keeps its beat unchanged
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_be));

    // R9: write data steady while the write waits
    p_wdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && !mem_gnt |=> $stable(mem_wdata));

    // R10: completion is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: error only alongside completion
    p_err_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R10: no beat offered in the completion cycle
    p_quiet_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    // R5: enables are a full word or a single lane
    p_be_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_be == 4'hF || $countones(mem_be) == 1));

    // R5: full-word beats are word aligned
    p_word_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_be == 4'hF |-> mem_addr[1:0] == 2'b00);

endmodule

bind lin2d_copy lin2d_copy_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .err      (err),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_gnt  (mem_gnt),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_be   (mem_be)
);

// File: tb/lin2d_copy_bench.sv
module lin2d_copy_bench;

    localparam int MEMSZ = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        multi_line = 1'b0;
    logic        remap_en = 1'b0;
    logic [2:0]  remap_dst_sel = 3'd0;
    logic [1:0]  comp_size_m1 = 2'd0;
    logic [31:0] src_base = '0, dst_base = '0, src_pitch = '0, dst_pitch = '0;
    logic [15:0] line_len = '0;
    logic [15:0] line_cnt = '0;
    logic [31:0] const_a = '0;
    logic        done, err, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_gnt = 1'b0;
    logic [31:0] mem_rdata;

    logic [7:0] mem  [MEMSZ];
    logic [7:0] refm [MEMSZ];

    int          q_addr[$];
    bit          q_we[$];
    logic [3:0]  q_be[$];
    logic [31:0] q_dat[$];

    int checks = 0;
    int errors = 0;
    int gcnt = 0;

    always #10 clk = ~clk;

    lin2d_copy u_lin2d_copy (
        .clk(clk), .rst_n(rst_n), .start(start), .multi_line(multi_line),
        .remap_en(remap_en), .remap_dst_sel(remap_dst_sel), .comp_size_m1(comp_size_m1),
        .src_base(src_base), .dst_base(dst_base), .src_pitch(src_pitch), .dst_pitch(dst_pitch),
        .line_len(line_len), .line_cnt(line_cnt), .const_a(const_a),
        .done(done), .err(err), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    function automatic int ix(input logic [31:0] a);
        return int'(a[8:0]);
    endfunction

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            mem_rdata[8*i +: 8] = mem[(ix(mem_addr) & ~3) + i];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_of(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    // Behavioural expectation: fills the beat queue and updates refm
    task automatic model(input logic [31:0] sb, input logic [31:0] db,
                         input logic [31:0] sp, input logic [31:0] dp,
                         input int len, input int cnt, input bit ml, input bit rm,
                         input logic [2:0] sel, input logic [1:0] cs,
                         input logic [31:0] ca, output bit e);
        int rows;
        bit word;
        logic [7:0] rb [64];
        e = 1'b0;
        if (rm) begin
            if (ml || sel != 3'd4 || cs != 2'd3 || db[1:0] != 2'b00) begin
                e = 1'b1;
                return;
            end
            for (int k = 0; k < len; k++) begin
                q_addr.push_back(int'(db) + 4 * k); q_we.push_back(1'b1);
                q_be.push_back(4'hF); q_dat.push_back(ca);
                for (int i = 0; i < 4; i++) refm[ix(db + 32'(4 * k + i))] = ca[8*i +: 8];
            end
            return;
        end
        rows = ml ? cnt : 1;
        if (len == 0 || rows == 0) return;
        if (len > 64) begin
            e = 1'b1;
            return;
        end
        word = (sb[1:0] == 0) && (db[1:0] == 0) && (len % 4 == 0) &&
               (!ml || (sp[1:0] == 0 && dp[1:0] == 0));
        for (int r = 0; r < rows; r++) begin
            logic [31:0] s, d;
            s = sb + 32'(r) * sp;
            d = db + 32'(r) * dp;
            for (int o = 0; o < len; o += (word ? 4 : 1)) begin
                logic [31:0] a;
                a = s + 32'(o);
                q_addr.push_back(int'(a)); q_we.push_back(1'b0);
                q_be.push_back(word ? 4'hF : 4'b0001 << a[1:0]); q_dat.push_back('0);
                for (int i = 0; i < (word ? 4 : 1); i++) rb[o + i] = refm[ix(a + 32'(i))];
            end
            for (int o = 0; o < len; o += (word ? 4 : 1)) begin
                logic [31:0] a;
                a = d + 32'(o);
                q_addr.push_back(int'(a)); q_we.push_back(1'b1);
                if (word) begin
                    q_be.push_back(4'hF);
                    q_dat.push_back({rb[o + 3], rb[o + 2], rb[o + 1], rb[o]});
                end else begin
                    q_be.push_back(4'b0001 << a[1:0]);
                    q_dat.push_back({4{rb[o]}});
                end
                for (int i = 0; i < (word ? 4 : 1); i++) refm[ix(a + 32'(i))] = rb[o + i];
            end
        end
    endtask

    task automatic run(input string req, input logic [31:0] sb, input logic [31:0] db,
                       input logic [31:0] sp, input logic [31:0] dp,
                       input int len, input int cnt, input bit ml, input bit rm,
                       input logic [2:0] sel, input logic [1:0] cs,
                       input logic [31:0] ca, input bit poke);
        bit exp_err;
        bit seen_done;
        int last;
        int bad;
        for (int i = 0; i < MEMSZ; i++) refm[i] = mem[i];
        q_addr.delete(); q_we.delete(); q_be.delete(); q_dat.delete();
        model(sb, db, sp, dp, len, cnt, ml, rm, sel, cs, ca, exp_err);
        @(negedge clk);
        src_base = sb; dst_base = db; src_pitch = sp; dst_pitch = dp;
        line_len = 16'(len); line_cnt = 16'(cnt); multi_line = ml; remap_en = rm;
        remap_dst_sel = sel; comp_size_m1 = cs; const_a = ca; start = 1'b1;
        last = 0;
        seen_done = 1'b0;
        for (int it = 1; it < 3000 && !seen_done; it++) begin
            @(negedge clk);
            start = 1'b0;
            if (poke && it == 3) begin
                // R2: a second start with altered setup while busy
                start = 1'b1;
                src_base = sb + 32'd64; dst_base = db + 32'd8;
                line_len = 16'(len + 3); multi_line = !ml; const_a = ~ca;
            end
            mem_gnt = (gcnt % 4) != 2;
            gcnt++;
            #1;
            if (mem_req && mem_gnt) begin
                if (q_addr.size() == 0) begin
                    chk(1'b0, req, "unexpected beat addr", mem_addr, 32'hFFFF_FFFF);
                end else begin
                    chk(mem_addr == 32'(q_addr[0]), req, "beat address (R11)", mem_addr, 32'(q_addr[0]));
                    chk(mem_we == q_we[0], req, "beat direction (R11)", 32'(mem_we), 32'(q_we[0]));
                    chk(mem_be == q_be[0], req, "beat enables (R5)", 32'(mem_be), 32'(q_be[0]));
                    if (q_we[0]) begin
                        chk((mem_wdata & mask_of(mem_be)) == (q_dat[0] & mask_of(q_be[0])),
                            req, "write data", mem_wdata, q_dat[0]);
                        for (int i = 0; i < 4; i++)
                            if (mem_be[i]) mem[(ix(mem_addr) & ~3) + i] = mem_wdata[8*i +: 8];
                    end
                    void'(q_addr.pop_front()); void'(q_we.pop_front());
                    void'(q_be.pop_front()); void'(q_dat.pop_front());
                end
                last = it;
            end
            if (done) begin
                seen_done = 1'b1;
                chk(it == last + 1, req, "done timing R10", 32'(it), 32'(last + 1));
                chk(err == exp_err, req, "err flag", 32'(err), 32'(exp_err));
                chk(q_addr.size() == 0, req, "beats left at done", 32'(q_addr.size()), 32'd0);
            end
        end
        start = 1'b0;
        chk(seen_done, req, "done never seen", 32'(seen_done), 32'd1);
        bad = -1;
        for (int i = 0; i < MEMSZ; i++) if (bad < 0 && mem[i] !== refm[i]) bad = i;
        chk(bad < 0, req, "memory image", (bad < 0) ? 32'd0 : 32'(mem[bad]),
            (bad < 0) ? 32'd0 : 32'(refm[bad]));
        multi_line = ml; line_len = 16'(len);
        @(negedge clk);
        chk(!done && !mem_req, req, "idle after job", {30'd0, done, mem_req}, 32'd0);
    endtask

    initial begin
        #(20 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEMSZ; i++) mem[i] = 8'(i * 37 + 5);
        repeat (3) @(negedge clk);
        #1;
        chk(!mem_req && !done, "R1", "reset outputs", {30'd0, mem_req, done}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        chk(!mem_req && !done, "R1", "idle after reset", {30'd0, mem_req, done}, 32'd0);

        run("R3", 32'h000, 32'h100, 0, 0, 16, 0, 0, 0, 0, 0, 0, 0);          // word 1D
        run("R5", 32'h021, 32'h143, 0, 0, 7, 0, 0, 0, 0, 0, 0, 0);           // byte 1D
        run("R4", 32'h040, 32'h180, 32, 16, 8, 3, 1, 0, 0, 0, 0, 0);         // word rows
        run("R4", 32'h061, 32'h1A2, 20, 13, 5, 4, 1, 0, 0, 0, 0, 0);         // byte rows
        run("R4", 32'h100, 32'h102, 8, 8, 8, 3, 1, 0, 0, 0, 0, 0);           // overlap
        run("R6", 32'h000, 32'h0C0, 0, 0, 5, 0, 0, 1, 3'd4, 2'd3, 32'hA5C3_1E77, 0);
        run("R8", 32'h000, 32'h100, 4, 4, 8, 0, 1, 0, 0, 0, 0, 0);           // no rows
        run("R8", 32'h000, 32'h100, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);           // no bytes
        run("R7", 32'h000, 32'h100, 4, 4, 8, 2, 1, 1, 3'd4, 2'd3, 32'h1, 0); // remap+rows
        run("R7", 32'h000, 32'h100, 0, 0, 8, 0, 0, 1, 3'd2, 2'd3, 32'h1, 0); // other sel
        run("R7", 32'h000, 32'h100, 0, 0, 8, 0, 0, 1, 3'd4, 2'd1, 32'h1, 0); // size
        run("R7", 32'h000, 32'h101, 0, 0, 8, 0, 0, 1, 3'd4, 2'd3, 32'h1, 0); // fill unaligned
        run("R7", 32'h000, 32'h100, 0, 0, 65, 0, 0, 0, 0, 0, 0, 0);          // too long
        run("R2", 32'h080, 32'h1C0, 12, 16, 12, 3, 1, 0, 0, 0, 0, 1);        // busy start
        run("R9", 32'h003, 32'h0F1, 0, 0, 9, 0, 0, 0, 0, 0, 0, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule